// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block sets up the two threshold registers that a synchronous FIFO uses for its near-empty and near-full flags. `xOffset` is the near-empty distance and `yOffset` is the near-full distance. Two configuration pins choose how the registers get their values. The block samples these pins while the active-low reset is held and keeps the last sampled value. The registers can then load a fixed preset (8 or 64), take the first two accepted words from the write port, or take a bit stream on the same two pins, where one pin is the data and the other is an active-low shift enable.

The block holds `inReady` low until programming ends. The FIFO core must accept a write only when `wrEn` arrives while `inReady` is high. The block raises `memWrite` only for writes that belong in the storage array. Configuration words are steered into the registers and never reach memory. The offset width is log2 of the FIFO depth. Values from 1 to depth minus 4 are the meaningful range, and the block stores whatever it is given. The storage array and the flag comparators sit outside this block.

Top module: `fifoOffsetProg`

## Requirements
- R1: The mode is taken from {cfgSelHi, cfgSelLo} as sampled on the last rising clock edge with rstN low. 2'b11 selects serial load, 2'b10 selects preset 64, 2'b01 selects preset 8, and 2'b00 selects parallel load.
- R2: While reset is applied, inReady, progDone and memWrite are low, and xOffset and yOffset are zero.
- R3: In a preset mode, both offsets take the preset value. inReady and progDone go high after the second rising edge following reset release, and stay low after the first.
- R4: In parallel mode, inReady goes high after the second edge following release. The first accepted write loads yOffset and the second loads xOffset. memWrite stays low for both, and progDone rises after the second.
- R5: An offset loaded from the write port equals wrLow, a binary number whose highest-numbered bit is the MSB.
- R6: In serial mode, one bit of cfgSelLo is shifted in on each edge where cfgSelHi is low. Edges with cfgSelHi high leave the offsets unchanged. Exactly 2*log2(DEPTH) bits complete the load.
- R7: In serial mode, the first bit becomes the MSB of yOffset and the last bit becomes the LSB of xOffset.
- R8: In serial mode, inReady stays low through the edge that takes the last bit. inReady and progDone go high on the following edge. Once high, inReady stays high until reset.
- R9: After progDone, memWrite equals wrEn and carries every write to memory, in order.
- R10: After progDone, activity on cfgSelHi and cfgSelLo leaves both offsets unchanged until the next reset.
- R11: wrEn while inReady is low loads nothing and raises no memWrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgSelHi | input | 1 | Mode select high bit; active-low shift enable in serial mode |
| cfgSelLo | input | 1 | Mode select low bit; serial data in serial mode |
| wrEn | input | 1 | Write request from the write port |
| wrLow | input | log2(DEPTH) | Low bits of the write data word |
| inReady | output | 1 | Write port may accept data |
| memWrite | output | 1 | Current write goes to FIFO memory |
| progDone | output | 1 | Offsets are final |
| xOffset | output | log2(DEPTH) | Near-empty offset |
| yOffset | output | log2(DEPTH) | Near-full offset |

## Verification
Two functions can meet in the same cycle. One is the load of the second offset word, which must not reach memory. The other is the first memory write, which the bench presents on the very next edge. The bench provokes this with back-to-back parallel writes that span the change into the done state. It also places a write on the edge where inReady rises, and that write must be dropped. A queue-based scoreboard records exactly which words should raise memWrite, so a register load that leaks into memory, or a memory write that is dropped, shows up as a mismatch or as a queue that is not empty at the end.

// File: rtl/fifoOffsetProgPkg.sv
package fifoOffsetProgPkg;

  typedef enum logic [1:0] {
    MODE_PARALLEL  = 2'b00,
    MODE_PRESET_LO = 2'b01,
    MODE_PRESET_HI = 2'b10,
    MODE_SERIAL    = 2'b11
  } loadMode_t;

  typedef enum logic [2:0] {
    ST_RESET,
    ST_SETTLE,
    ST_LOAD_Y,
    ST_LOAD_X,
    ST_SHIFT,
    ST_SHIFT_END,
    ST_DONE
  } progState_t;

  typedef struct packed {
    logic loadPreset;
    logic presetHi;
    logic shiftEn;
    logic loadY;
    logic loadX;
  } ofsStrobes_t;

endpackage

// File: rtl/fifoOffsetCtrl.sv
module fifoOffsetCtrl
  import fifoOffsetProgPkg::*;
#(
  parameter int SER_BITS = 18
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgSelHi,
  input  logic        cfgSelLo,
  input  logic        wrEn,
  output ofsStrobes_t strobes,
  output logic        inReady,
  output logic        progDone
);

  localparam int CNT_W = $clog2(SER_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SER_BITS - 1);

  loadMode_t        mode;
  progState_t       state, nextState;
  logic [CNT_W-1:0] bitCnt;

  // mode is sampled on every edge that sees reset low; the last one wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_RESET;
      mode   <= loadMode_t'({cfgSelHi, cfgSelLo});
      bitCnt <= '0;
    end else begin
      state <= nextState;
      if (strobes.shiftEn) bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    unique case (state)
      ST_RESET: begin
        if (mode == MODE_SERIAL) begin
          nextState = ST_SHIFT;
        end else begin
          nextState = ST_SETTLE;
          if (mode != MODE_PARALLEL) begin
            strobes.loadPreset = 1'b1;
            strobes.presetHi   = (mode == MODE_PRESET_HI);
          end
        end
      end
      ST_SETTLE: nextState = (mode == MODE_PARALLEL) ? ST_LOAD_Y : ST_DONE;
      ST_LOAD_Y: begin
        if (wrEn) begin
          strobes.loadY = 1'b1;
          nextState     = ST_LOAD_X;
        end
      end
      ST_LOAD_X: begin
        if (wrEn) begin
          strobes.loadX = 1'b1;
          nextState     = ST_DONE;
        end
      end
      ST_SHIFT: begin
        if (!cfgSelHi) begin
          strobes.shiftEn = 1'b1;
          if (bitCnt == LAST_BIT) nextState = ST_SHIFT_END;
        end
      end
      ST_SHIFT_END: nextState = ST_DONE;
      ST_DONE:      nextState = ST_DONE;
      default:      nextState = ST_RESET;
    endcase
  end

  assign inReady  = (state == ST_LOAD_Y) || (state == ST_LOAD_X) || (state == ST_DONE);
  assign progDone = (state == ST_DONE);

endmodule

// File: rtl/fifoOffsetRegs.sv
module fifoOffsetRegs
  import fifoOffsetProgPkg::*;
#(
  parameter int OFF_W     = 9,
  parameter int PRESET_LO = 8,
  parameter int PRESET_HI = 64
) (
  input  logic             clk,
  input  logic             rstN,
  input  ofsStrobes_t      strobes,
  input  logic             serBit,
  input  logic [OFF_W-1:0] wrLow,
  output logic [OFF_W-1:0] xOffset,
  output logic [OFF_W-1:0] yOffset
);

  logic [OFF_W-1:0] xReg, yReg;
  logic [OFF_W-1:0] presetVal;

  assign presetVal = strobes.presetHi ? OFF_W'(PRESET_HI) : OFF_W'(PRESET_LO);

  // serial load shifts through {y, x} so the first bit ends as y's MSB
  always_ff @(posedge clk) begin
    if (!rstN) begin
      xReg <= '0;
      yReg <= '0;
    end else if (strobes.loadPreset) begin
      xReg <= presetVal;
      yReg <= presetVal;
    end else if (strobes.shiftEn) begin
      {yReg, xReg} <= {yReg[OFF_W-2:0], xReg, serBit};
    end else begin
      if (strobes.loadY) yReg <= wrLow;
      if (strobes.loadX) xReg <= wrLow;
    end
  end

  assign xOffset = xReg;
  assign yOffset = yReg;

endmodule

// File: rtl/fifoOffsetProg.sv
module fifoOffsetProg
  import fifoOffsetProgPkg::*;
#(
  parameter int DEPTH     = 512,
  parameter int PRESET_LO = 8,
  parameter int PRESET_HI = 64,
  localparam int OFF_W    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgSelHi,
  input  logic             cfgSelLo,
  input  logic             wrEn,
  input  logic [OFF_W-1:0] wrLow,
  output logic             inReady,
  output logic             memWrite,
  output logic             progDone,
  output logic [OFF_W-1:0] xOffset,
  output logic [OFF_W-1:0] yOffset
);

  localparam int SER_BITS = 2 * OFF_W;

  ofsStrobes_t strobes;

  fifoOffsetCtrl #(.SER_BITS(SER_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgSelHi (cfgSelHi),
    .cfgSelLo (cfgSelLo),
    .wrEn     (wrEn),
    .strobes  (strobes),
    .inReady  (inReady),
    .progDone (progDone)
  );

  fifoOffsetRegs #(
    .OFF_W     (OFF_W),
    .PRESET_LO (PRESET_LO),
    .PRESET_HI (PRESET_HI)
  ) u_regs (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .serBit  (cfgSelLo),
    .wrLow   (wrLow),
    .xOffset (xOffset),
    .yOffset (yOffset)
  );

  assign memWrite = wrEn && progDone;

endmodule

// File: rtl/fifoOffsetProgChk.sv
module fifoOffsetProgChk #(
  parameter int OFF_W = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             inReady,
  input logic             memWrite,
  input logic             progDone,
  input logic [OFF_W-1:0] xOffset,
  input logic [OFF_W-1:0] yOffset
);

  // R8: once ready, stays ready until reset
  a_r8_ready_sticky: assert property (@(posedge clk) disable iff (!rstN)
    inReady |=> inReady);

  // R3/R8: done never precedes ready
  a_r3_done_implies_ready: assert property (@(posedge clk) disable iff (!rstN)
    progDone |-> inReady);

  // R11: nothing reaches memory while the port is not ready
  a_r11_no_mem_unready: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |-> !memWrite);

  // R10: offsets are frozen after programming completes
  a_r10_offsets_frozen: assert property (@(posedge clk) disable iff (!rstN)
    progDone |=> ($stable(xOffset) && $stable(yOffset)));

  // R9: memory write only appears with a request
  a_r9_mem_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> wrEn);

endmodule

bind fifoOffsetProg fifoOffsetProgChk #(.OFF_W(OFF_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .inReady  (inReady),
  .memWrite (memWrite),
  .progDone (progDone),
  .xOffset  (xOffset),
  .yOffset  (yOffset)
);

// File: tb/tb_fifoOffsetProg.sv
`timescale 1ns/1ps
module tb_fifoOffsetProg;

  localparam int DEPTH = 512;
  localparam int OFF_W = $clog2(DEPTH);
  localparam int SER_BITS = 2 * OFF_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             cfgSelHi = 1'b0;
  logic             cfgSelLo = 1'b0;
  logic             wrEn = 1'b0;
  logic [OFF_W-1:0] wrLow = '0;
  logic             inReady, memWrite, progDone;
  logic [OFF_W-1:0] xOffset, yOffset;

  int nChecks = 0;
  int nFails  = 0;
  logic [OFF_W-1:0] memQ[$];

  fifoOffsetProg #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .cfgSelHi(cfgSelHi), .cfgSelLo(cfgSelLo),
    .wrEn(wrEn), .wrLow(wrLow), .inReady(inReady), .memWrite(memWrite),
    .progDone(progDone), .xOffset(xOffset), .yOffset(yOffset)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // driver: one write, pushing the expected memory word when it should land
  task automatic writeWord(input logic [OFF_W-1:0] data, input bit toMem);
    wrEn  = 1'b1;
    wrLow = data;
    if (toMem) memQ.push_back(data);
    step();
    wrEn = 1'b0;
  endtask

  // monitor: every memWrite must match the head of the scoreboard
  always @(negedge clk) begin
    if (rstN && memWrite) begin
      nChecks++;
      if (memQ.size() == 0) begin
        nFails++;
        $display("FAIL R9/R4/R11: actual unexpected memWrite %0h expected none", wrLow);
      end else begin
        logic [OFF_W-1:0] e;
        e = memQ.pop_front();
        if (wrLow !== e) begin
          nFails++;
          $display("FAIL R9: actual %0h expected %0h", wrLow, e);
        end
      end
    end
  end

  task automatic applyReset(input logic hi, input logic lo);
    rstN = 1'b0;
    cfgSelHi = hi;
    cfgSelLo = lo;
    wrEn = 1'b0;
    repeat (3) step();
  endtask

  task automatic presetRun(input logic hi, input logic lo, input int val);
    applyReset(hi, lo);
    rstN = 1'b1;
    step();
    check("R3 ready low after first edge", inReady, 0);
    step();
    check("R3 ready after second edge", inReady, 1);
    check("R3 done", progDone, 1);
    check("R1/R3 x preset", xOffset, val);
    check("R1/R3 y preset", yOffset, val);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [SER_BITS-1:0] vec;
    // ---- parallel mode ----
    applyReset(1'b0, 1'b0);
    check("R2 ready in reset", inReady, 0);
    check("R2 done in reset", progDone, 0);
    check("R2 mem in reset", memWrite, 0);
    check("R2 offsets in reset", {xOffset, yOffset}, 0);
    rstN = 1'b1;
    wrEn = 1'b1; wrLow = 9'h1AA;           // R11: must be ignored
    step();
    check("R4 ready low after first edge", inReady, 0);
    step();                                 // write on the edge that raises ready
    wrEn = 1'b0;
    check("R4 ready after second edge", inReady, 1);
    check("R11 no load while unready", {xOffset, yOffset}, 0);
    check("R4 not done yet", progDone, 0);
    writeWord(9'h1F0, 1'b0);                // Y
    check("R4/R5 y from first write", yOffset, 9'h1F0);
    check("R4 still not done", progDone, 0);
    writeWord(9'h003, 1'b0);                // X, next write back to back
    check("R4/R5 x from second write", xOffset, 9'h003);
    check("R4 done after second", progDone, 1);
    writeWord(9'h055, 1'b1);
    writeWord(9'h100, 1'b1);
    writeWord(9'h1FC, 1'b1);
    check("R9 offsets kept", {xOffset, yOffset}, {9'h003, 9'h1F0});
    check("R9 all mem writes seen", memQ.size(), 0);

    // ---- presets ----
    presetRun(1'b1, 1'b0, 64);
    presetRun(1'b0, 1'b1, 8);

    // ---- serial mode ----
    vec = {9'h1A5, 9'h00B};
    applyReset(1'b1, 1'b1);
    rstN = 1'b1;
    step();
    for (int i = SER_BITS - 1; i >= 0; i--) begin
      if (i == 9 || i == 4) begin
        cfgSelHi = 1'b1; cfgSelLo = ~vec[i];
        wrEn = 1'b1; wrLow = 9'h0AA;          // R11: no memWrite mid-load
        step();
        wrEn = 1'b0;
        check("R6 idle edge holds", {yOffset, xOffset}, 32'(vec >> (i + 1)));
        check("R8 ready low mid-load", inReady, 0);
      end
      cfgSelHi = 1'b0; cfgSelLo = vec[i];
      step();
      if (i == 1) check("R6 ready low after 17 bits", inReady, 0);
    end
    check("R8 ready low on last-bit edge", inReady, 0);
    cfgSelHi = 1'b1;
    step();
    check("R8 ready after last bit", inReady, 1);
    check("R8 done after last bit", progDone, 1);
    check("R7 y value", yOffset, 9'h1A5);
    check("R7 x value", xOffset, 9'h00B);
    cfgSelHi = 1'b0; cfgSelLo = 1'b1;
    repeat (5) step();
    cfgSelHi = 1'b1;
    check("R10 offsets unchanged", {yOffset, xOffset}, {9'h1A5, 9'h00B});
    writeWord(9'h0F1, 1'b1);
    check("R9 serial-mode write reached memory", memQ.size(), 0);

    step();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule